// File: doc/BRIEF.md
# System Tick Timer

A 24-bit down-counter that gives a processor a regular time base. It sits in the system control space and has four word registers on a simple single-cycle read/write bus. Software writes a reload value and then sets the run bit. The counter steps down once per counting tick. It takes one more tick to reach zero and reload, so a period is reload+1 ticks.

The counting tick is chosen by a source bit in the control register. With the bit set, the counter steps on every core clock cycle. With the bit clear, it steps only on cycles where the external reference tick input is high. Each wrap sets a sticky count flag. If the tick-interrupt bit is set, the wrap also raises a one-cycle pending pulse toward the interrupt controller.

The flag is cleared by reading the control register or by writing the current-value register. A reload value of zero at expiry stops the timer.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset every register reads zero, except calibration, which reads 10000. The pending pulse is low.
- R2: The control register is at offset 0x10. Bit 0 is run, bit 1 is tick-interrupt enable, bit 2 is source select (1 = core clock, 0 = reference tick) and bit 16 is the count flag. A write changes only bits 2:0. All other bits read zero.
- R3: The reload register is at offset 0x14 and holds 24 bits. Written bits 31:24 are dropped, and those bits read zero.
- R4: Setting run while the count is zero loads the reload value. While running, the counter decrements once per counting tick. The counting tick that finds the count at zero reloads it and sets the count flag, so wraps are reload+1 ticks apart.
- R5: With source select 1 every cycle is a counting tick. With source select 0 only cycles with the reference tick high count.
- R6: The pending pulse is high for exactly the one cycle after a wrap, and only when tick-interrupt enable is set.
- R7: A read of the control register returns the flag, and the flag is then cleared. A wrap in the same cycle as that read leaves the flag set.
- R8: Any write to the current-value register (offset 0x18) clears the flag. While running it loads the reload value into the counter. While stopped it zeroes the counter. The write data is ignored.
- R9: A wrap with a reload value of zero clears the run bit.
- R10: The current-value register reads zero while stopped. Clearing run freezes the count. Setting run again with a nonzero frozen count resumes from that count.
- R11: The calibration register at offset 0x1C always reads 10000, and writes to it are ignored.
- R12: A control write that flips source select while run stays set reloads the counter.
- R13: A cycle that carries a write to the control or current-value register is not a counting tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of a read access |
| refTick | input | 1 | External reference counting tick |
| irqPulse | output | 1 | One-cycle interrupt-pending request |

## Verification
The reload value is swept from 0 to 9 on the core clock. For each value the bench measures the cycles from the run write to the first pending pulse and to the next one. This separates off-by-one period errors from missing reloads, and reload 0 covers the self-stop.

A slow reference tick pattern, one high cycle in three, separates counting on reference ticks from counting on every cycle. Holding the reference tick low shows that the count stands still.

Separate runs cover the remaining orderings:
- a flag read that lands in the cycle of a wrap, which shows whether the set or the clear wins;
- freeze and resume;
- writes to the current-value register while running and while stopped;
- a source flip while running;
- a control write that leaves the state unchanged, which shows whether write cycles are taken out of counting.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int OFF_CTRL   = 'h10;
  localparam int OFF_RELOAD = 'h14;
  localparam int OFF_CUR    = 'h18;
  localparam int OFF_CALIB  = 'h1C;
  localparam int DATA_W     = 32;
  localparam int FLAG_BIT   = 16;

  typedef struct packed {
    logic load;      // counter takes the reload value
    logic zero;      // counter forced to zero
    logic countEn;   // this cycle is a counting tick while running
    logic wrReload;  // reload register write
  } stk_strobe_t;
endpackage

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  stk_strobe_t      str,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] reloadVal,
  output logic             cntIsZero,
  output logic             relIsZero,
  output logic             wrapEv
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reloadR;

  assign cntVal    = cnt;
  assign reloadVal = reloadR;
  assign cntIsZero = (cnt == '0);
  assign relIsZero = (reloadR == '0);
  assign wrapEv    = str.countEn && cntIsZero;

  always_ff @(posedge clk) begin
    if (!rstN) reloadR <= '0;
    else if (str.wrReload) reloadR <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             cnt <= '0;
    else if (str.zero)     cnt <= '0;
    else if (str.load)     cnt <= reloadR;
    else if (str.countEn) begin
      if (cntIsZero) cnt <= reloadR;
      else           cnt <= cnt - CNT_W'(1);
    end
  end

  // R4
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.countEn && !cntIsZero) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R10
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!str.countEn && !str.load && !str.zero) |=> $stable(cnt));

  // R8
  cnt_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.zero |=> cntIsZero);
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8,
  parameter int CALIB  = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        wdataLow,
  output logic [DATA_W-1:0] busRdata,
  input  logic              refTick,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic              cntIsZero,
  input  logic              relIsZero,
  input  logic              wrapEv,
  output stk_strobe_t       str,
  output logic              irqPulse
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic runR, intEnR, srcR, flagR, irqR;
  logic hitCtrl, hitRel, hitCur, hitCal;
  logic wrCtrl, wrCur, rdCtrl;

  assign hitCtrl = (busAddr == ADDR_W'(OFF_CTRL));
  assign hitRel  = (busAddr == ADDR_W'(OFF_RELOAD));
  assign hitCur  = (busAddr == ADDR_W'(OFF_CUR));
  assign hitCal  = (busAddr == ADDR_W'(OFF_CALIB));

  assign wrCtrl = busValid && busWrite && hitCtrl;
  assign wrCur  = busValid && busWrite && hitCur;
  assign rdCtrl = busValid && !busWrite && hitCtrl;

  always_comb begin
    str.wrReload = busValid && busWrite && hitRel;
    str.zero     = wrCur && !runR;
    str.load     = (wrCur && runR)
                || (wrCtrl && wdataLow[0] && !runR && cntIsZero)
                || (wrCtrl && wdataLow[0] && runR && (wdataLow[2] != srcR));
    str.countEn  = runR && !wrCtrl && !wrCur && (srcR || refTick);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runR   <= 1'b0;
      intEnR <= 1'b0;
      srcR   <= 1'b0;
    end else if (wrCtrl) begin
      runR   <= wdataLow[0];
      intEnR <= wdataLow[1];
      srcR   <= wdataLow[2];
    end else if (wrapEv && relIsZero) begin
      runR   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 flagR <= 1'b0;
    else if (wrapEv)           flagR <= 1'b1;
    else if (rdCtrl || wrCur)  flagR <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqR <= 1'b0;
    else       irqR <= wrapEv && intEnR;
  end
  assign irqPulse = irqR;

  always_comb begin
    busRdata = '0;
    if (busValid && !busWrite) begin
      if (hitCtrl) begin
        busRdata[FLAG_BIT] = flagR;
        busRdata[2:0]      = {srcR, intEnR, runR};
      end else if (hitRel) begin
        busRdata = {{PAD_W{1'b0}}, reloadVal};
      end else if (hitCur) begin
        busRdata = runR ? {{PAD_W{1'b0}}, cntVal} : '0;
      end else if (hitCal) begin
        busRdata = DATA_W'(CALIB);
      end
    end
  end

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R6
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> flagR);

  // R9
  self_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEv && relIsZero) |=> !runR);

  // R13
  write_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && (hitCtrl || hitCur)) |-> !str.countEn);

  // R7
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEv && rdCtrl) |=> flagR);
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import stk_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8,
  parameter int CALIB  = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              refTick,
  output logic              irqPulse
);
  stk_strobe_t      str;
  logic [CNT_W-1:0] cntVal, reloadVal;
  logic             cntIsZero, relIsZero, wrapEv;
  logic             unusedBits;

  assign unusedBits = ^busWdata[31:CNT_W];

  stk_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CALIB(CALIB)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .wdataLow(busWdata[2:0]), .busRdata(busRdata), .refTick(refTick),
    .cntVal(cntVal), .reloadVal(reloadVal), .cntIsZero(cntIsZero),
    .relIsZero(relIsZero), .wrapEv(wrapEv), .str(str), .irqPulse(irqPulse)
  );

  stk_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .str(str), .wdata(busWdata[CNT_W-1:0]),
    .cntVal(cntVal), .reloadVal(reloadVal), .cntIsZero(cntIsZero),
    .relIsZero(relIsZero), .wrapEv(wrapEv)
  );
endmodule

// File: tb/sys_tick_timer_test.sv
`timescale 1ns/1ps
module sys_tick_timer_test;
  localparam logic [7:0] A_CTRL = 8'h10, A_REL = 8'h14, A_CUR = 8'h18, A_CAL = 8'h1C;

  logic clk = 0, rstN = 0, busValid = 0, busWrite = 0, refTick = 0, irqPulse;
  logic [7:0] busAddr = 0;
  logic [31:0] busWdata = 0, busRdata;
  int total = 0, bad = 0;
  bit refOn = 0;
  bit doneFlag = 0;
  int cyc = 0;

  sys_tick_timer uut (.clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .refTick(refTick), .irqPulse(irqPulse));

  always #2 clk = ~clk;

  initial forever begin
    @(posedge clk); #1;
    cyc++;
    refTick = refOn && (cyc % 3 == 0);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busValid = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1;
    busValid = 0;
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!irqPulse && n < 100);
  endtask

  task automatic idle(input int k);
    repeat (k) begin @(posedge clk); #1; end
  endtask

  task automatic clearTimer();
    logic [31:0] d;
    busWr(A_CTRL, 0);
    busWr(A_CUR, 0);
    busRd(A_CTRL, d);
  endtask

  initial begin
    #(4 * 150000);
    if (!doneFlag) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    idle(3);
    rstN = 1;
    idle(1);

    // R1 reset state
    busRd(A_CTRL, d); chk("R1 ctrl", d, 0);
    busRd(A_REL, d);  chk("R1 reload", d, 0);
    busRd(A_CUR, d);  chk("R1 current", d, 0);
    chk("R1 irq", {31'b0, irqPulse}, 0);

    // R11 calibration constant, write ignored
    busRd(A_CAL, d); chk("R11 calib", d, 10000);
    busWr(A_CAL, 32'h12345678);
    busRd(A_CAL, d); chk("R11 calib after write", d, 10000);

    // R2 only bits 2:0 writable
    busWr(A_CTRL, 32'hFFFFFFF8);
    busRd(A_CTRL, d); chk("R2 upper bits", d, 0);
    busWr(A_CTRL, 32'h6);
    busRd(A_CTRL, d); chk("R2 int+src", d, 32'h6);
    busWr(A_CTRL, 0);

    // R3 reload 24 bits
    busWr(A_REL, 32'hABCDEF12);
    busRd(A_REL, d); chk("R3 reload width", d, 32'h00CDEF12);

    // R4 / R9 / R6 / R7 sweep over reload values on core clock
    for (int r = 0; r < 10; r++) begin
      clearTimer();
      busWr(A_REL, r);
      busWr(A_CTRL, 32'h7);
      waitIrq(n); chk("R4 first period", n, r + 1);
      @(posedge clk); #1; chk("R6 pulse width", {31'b0, irqPulse}, 0);
      if (r == 0) begin
        busRd(A_CTRL, d); chk("R9 self stop", d, 32'h10006);
        idle(3); chk("R9 no further pulse", {31'b0, irqPulse}, 0);
        busRd(A_CTRL, d); chk("R7 flag cleared", d, 32'h6);
      end else begin
        waitIrq(n); chk("R4 second period", n, r);
        busWr(A_CTRL, 32'h6);
        busRd(A_CTRL, d); chk("R7 flag read", d, 32'h10006);
        busRd(A_CTRL, d); chk("R7 flag cleared", d, 32'h6);
      end
    end
    // second period measured from cycle after pulse: r+1 edges minus the width-check edge

    // R6 no pulse when tick-interrupt disabled
    clearTimer();
    busWr(A_REL, 3);
    busWr(A_CTRL, 32'h5);
    n = 0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1; if (irqPulse) n++;
    end
    chk("R6 no pulse without enable", n, 0);
    busWr(A_CTRL, 32'h4);
    busRd(A_CTRL, d); chk("R6 flag still set", d, 32'h10004);

    // R7 wrap coincident with control read
    clearTimer();
    busWr(A_REL, 3);
    busWr(A_CTRL, 32'h7);
    idle(3);
    busRd(A_CTRL, d); chk("R7 read before wrap", d, 32'h7);
    chk("R7 pulse at coincident wrap", {31'b0, irqPulse}, 1);
    busWr(A_CTRL, 32'h6);
    busRd(A_CTRL, d); chk("R7 set wins over clear", d, 32'h10006);

    // R13 control write cycle does not count
    clearTimer();
    busWr(A_REL, 20);
    busWr(A_CTRL, 32'h7);
    busWr(A_CTRL, 32'h7);
    busRd(A_CUR, d); chk("R13 no count in write cycle", d, 20);

    // R10 freeze and resume
    clearTimer();
    busWr(A_REL, 20);
    busWr(A_CTRL, 32'h7);
    idle(5);
    busWr(A_CTRL, 32'h6);
    busRd(A_CUR, d); chk("R10 reads zero when stopped", d, 0);
    idle(3);
    busWr(A_CTRL, 32'h7);
    busRd(A_CUR, d); chk("R10 resume value", d, 15);
    waitIrq(n); chk("R10 resume period", n, 15);

    // R8 current-value write
    clearTimer();
    busWr(A_REL, 10);
    busWr(A_CTRL, 32'h7);
    waitIrq(n); chk("R8 setup period", n, 11);
    busWr(A_CUR, 32'hFFFFFF);
    busRd(A_CTRL, d); chk("R8 flag cleared", d, 32'h7);
    busRd(A_CUR, d); chk("R8 reloaded", d, 9);
    busWr(A_CTRL, 32'h6);
    busWr(A_CUR, 32'h5);
    busWr(A_CTRL, 32'h7);
    waitIrq(n); chk("R8 zeroed while stopped", n, 11);

    // R12 source flip while running
    clearTimer();
    busWr(A_REL, 10);
    busWr(A_CTRL, 32'h7);
    idle(4);
    busWr(A_CTRL, 32'h3);
    busRd(A_CUR, d); chk("R12 reload on source flip", d, 10);
    idle(3);
    busRd(A_CUR, d); chk("R5 no ref tick no count", d, 10);

    // R5 counting on reference ticks
    clearTimer();
    busWr(A_REL, 4);
    refOn = 1;
    busWr(A_CTRL, 32'h3);
    n = 0;
    for (int k = 0; k < 100; k++) begin
      logic t;
      @(negedge clk); t = refTick;
      @(posedge clk); #1;
      if (t) n++;
      if (irqPulse) break;
    end
    chk("R5 ref tick period", n, 5);
    refOn = 0;

    doneFlag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule